// File: doc/BRIEF.md
# Match Timer with Pending Clear

This block is an event timer for a chip that keeps time on a slow timer clock while software reaches it from a faster bus clock. An up-counter in the timer domain advances once per timer clock, or once per four timer clocks when the divide setting is selected. When it steps onto a programmed compare value it raises an interrupt pulse in the bus domain. An optional auto-zero mode turns the timer into a periodic event source.

A write to the clear register zeroes the counter. The zeroing happens in the timer clock domain, several slow cycles after the bus write. The block keeps a pending flag in its status register until the timer domain has acknowledged the zeroing. Software should stop the timer, clear the count, write the compare value, poll the flag until it reads zero, and only then set the run bit. With that order the counter always starts from zero, so the compare event cannot be skipped because the old count was already past the compare value.

The current count crosses back to the bus domain in Gray code. A read therefore never combines bits from two different counts while the counter is stepping.

Top module: `match_timer`

## Requirements
- R1: After reset, every readable register reads zero: compare (0x00), count (0x04), control (0x08), divide select (0x10) and status (0x14).
- R2: A read drives bus_rvalid high in the cycle after bus_rd, with the data. Compare, control bits [1:0] and divide select bits [1:0] read back the values written. A read of an unmapped offset returns zero.
- R3: While control bit 0 (run) is set and divide select is not 3, the count at 0x04 advances once per timer clock. While run is clear, the count holds its value.
- R4: With divide select equal to 3, a running count advances once per four timer clocks.
- R5: A write of any data to the clear offset 0x0C zeroes the count in the timer domain.
- R6: Status bit 10 (clear pending) is set in the cycle after a clear write. It stays set until the zeroing has been acknowledged back into the bus domain, which takes more than one round trip of synchronizer stages.
- R7: A clear write made while a clear is pending keeps the flag set and causes one more full zeroing round trip. The flag then returns to zero and the count reads zero.
- R8: When a running counter steps onto the compare value, irq pulses high for exactly one bus cycle. Without auto-zero the counter continues past the compare value.
- R9: With control bit 1 (auto-zero) set, the counter returns to zero in place of the compare value. Events repeat every compare-value ticks, and the count stays below the compare value.
- R10: While run is clear, no irq pulse occurs.
- R11: If software clears the count, writes the compare value, waits for the pending flag to read zero and then sets run, exactly one event follows, even when the old count was beyond the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| irq | output | 1 | One-bus-cycle pulse per compare event |

## Verification
The hardest case to reach is a second clear that arrives while the first clear is still crossing the clock boundary. If that second clear were dropped, the pending flag would simply fall early. The bench stops the counter at a non-zero value and issues two clear writes two bus cycles apart. It then measures how long the flag stays set and requires that time to exceed a single-clear round trip by a clear margin. The bench also reproduces the race the flag exists to prevent: it parks the count far beyond a small compare value and then follows the documented programming order, and exactly one event must follow.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MATCH  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLKSEL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h14;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_AUTOZ = 1;
  localparam int STAT_PEND  = 10;
  localparam logic [1:0] CLKSEL_DIV4 = 2'd3;

  typedef struct packed {
    logic run;
    logic autoz;
    logic div4;
  } tmr_cfg_t;
endpackage

// File: rtl/mt_sync.sv
module mt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mt_tick_counter.sv
module mt_tick_counter
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_cfg_t         cfg,
  input  logic             req_s,
  input  logic [CNT_W-1:0] match_val,
  output logic             ack_tgl,
  output logic             evt_tgl,
  output logic [CNT_W-1:0] cnt_gray,
  output logic [CNT_W-1:0] cnt_q,
  output logic             clr_hit
);
  localparam int PRE_W = 2;
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hit;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign clr_hit = req_s ^ ack_tgl;
  assign tick    = cfg.run && (!cfg.div4 || (pre_q == PRE_LAST));
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = !clr_hit && tick && (cnt_inc == match_val);

  always_comb begin
    cnt_nxt = cnt_q;
    if (clr_hit)             cnt_nxt = '0;
    else if (hit && cfg.autoz) cnt_nxt = '0;
    else if (tick)           cnt_nxt = cnt_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tgl  <= 1'b0;
      evt_tgl  <= 1'b0;
      cnt_q    <= '0;
      cnt_gray <= '0;
      pre_q    <= '0;
    end else begin
      ack_tgl  <= req_s;
      cnt_q    <= cnt_nxt;
      cnt_gray <= bin2gray(cnt_nxt);
      if (clr_hit || !(cfg.run && cfg.div4)) pre_q <= '0;
      else                                    pre_q <= pre_q + 1'b1;
      if (hit) evt_tgl <= ~evt_tgl;
    end
  end
endmodule

// File: rtl/mt_bus_regs.sv
module mt_bus_regs
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic [CNT_W-1:0]  cnt_gray_s,
  input  logic              ack_s,
  input  logic              evt_s,
  output logic [CNT_W-1:0]  match_q,
  output logic [1:0]        ctrl_q,
  output logic [1:0]        clksel_q,
  output logic              req_tgl,
  output logic              clr_pend,
  output logic              irq
);
  logic              clr_wr;
  logic              ack_back;
  logic              redo_q;
  logic              evt_d;
  logic [CNT_W-1:0]  cnt_bin;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign clr_wr   = wr_en && (addr == OFS_CLEAR);
  assign ack_back = (ack_s == req_tgl);
  assign cnt_bin  = gray2bin(cnt_gray_s);

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= '0;
      ctrl_q   <= '0;
      clksel_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_MATCH:  match_q  <= wdata[CNT_W-1:0];
        OFS_CTRL:   ctrl_q   <= wdata[1:0];
        OFS_CLKSEL: clksel_q <= wdata[1:0];
        default: ;
      endcase
    end
  end

  // clear handshake: toggle out, wait for toggle back, replay a merged clear
  always_ff @(posedge clk) begin
    if (rst) begin
      req_tgl  <= 1'b0;
      clr_pend <= 1'b0;
      redo_q   <= 1'b0;
    end else if (clr_pend) begin
      if (ack_back) begin
        if (redo_q || clr_wr) begin
          req_tgl <= ~req_tgl;
          redo_q  <= 1'b0;
        end else begin
          clr_pend <= 1'b0;
        end
      end else if (clr_wr) begin
        redo_q <= 1'b1;
      end
    end else if (clr_wr) begin
      req_tgl  <= ~req_tgl;
      clr_pend <= 1'b1;
    end
  end

  // event toggle to pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_d <= 1'b0;
      irq   <= 1'b0;
    end else begin
      evt_d <= evt_s;
      irq   <= evt_s ^ evt_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_MATCH:  rd_mux = DATA_W'(match_q);
      OFS_COUNT:  rd_mux = DATA_W'(cnt_bin);
      OFS_CTRL:   rd_mux = DATA_W'(ctrl_q);
      OFS_CLKSEL: rd_mux = DATA_W'(clksel_q);
      OFS_STAT:   rd_mux[STAT_PEND] = clr_pend;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              tmr_clk,
  input  logic              tmr_rst,
  output logic              irq
);
  localparam int CFG_W = $bits(tmr_cfg_t);

  logic [CNT_W-1:0] match_q;
  logic [1:0]       ctrl_q;
  logic [1:0]       clksel_q;
  logic             req_tgl;
  logic             clr_pend;
  tmr_cfg_t         cfg_b;
  tmr_cfg_t         cfg_t;
  logic             req_s;
  logic             ack_tgl;
  logic             evt_tgl;
  logic             ack_s;
  logic             evt_s;
  logic [CNT_W-1:0] gray_t;
  logic [CNT_W-1:0] gray_s;
  logic [CNT_W-1:0] cnt_t;
  logic             clr_hit_t;

  assign cfg_b.run   = ctrl_q[CTRL_RUN];
  assign cfg_b.autoz = ctrl_q[CTRL_AUTOZ];
  assign cfg_b.div4  = (clksel_q == CLKSEL_DIV4);

  mt_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(bus_clk), .rst(bus_rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .rd_valid(bus_rvalid),
    .cnt_gray_s(gray_s), .ack_s(ack_s), .evt_s(evt_s),
    .match_q(match_q), .ctrl_q(ctrl_q), .clksel_q(clksel_q),
    .req_tgl(req_tgl), .clr_pend(clr_pend), .irq(irq)
  );

  mt_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_sync_cfg (
    .clk(tmr_clk), .rst(tmr_rst), .d(cfg_b), .q(cfg_t)
  );
  mt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_req (
    .clk(tmr_clk), .rst(tmr_rst), .d(req_tgl), .q(req_s)
  );

  mt_tick_counter #(.CNT_W(CNT_W)) u_core (
    .clk(tmr_clk), .rst(tmr_rst), .cfg(cfg_t), .req_s(req_s),
    .match_val(match_q), .ack_tgl(ack_tgl), .evt_tgl(evt_tgl),
    .cnt_gray(gray_t), .cnt_q(cnt_t), .clr_hit(clr_hit_t)
  );

  mt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_s)
  );
  mt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_evt (
    .clk(bus_clk), .rst(bus_rst), .d(evt_tgl), .q(evt_s)
  );
  mt_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync_cnt (
    .clk(bus_clk), .rst(bus_rst), .d(gray_t), .q(gray_s)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import mt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              bus_clk,
  input logic              bus_rst,
  input logic              tmr_clk,
  input logic              tmr_rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              clr_pend,
  input logic              irq,
  input logic              t_run,
  input logic              t_clr_hit,
  input logic [CNT_W-1:0]  t_cnt
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == OFS_CLEAR);

  // R8: an event is a single-cycle pulse
  assert_irq_single_R8: assert property (@(posedge bus_clk) disable iff (bus_rst)
    irq |=> !irq);

  // R6: a clear write raises the pending flag in the next cycle
  assert_pend_set_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
    clr_wr |=> clr_pend);

  // R7: a clear merged into a pending one never lets the flag fall
  assert_pend_merge_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (clr_wr && clr_pend) |=> clr_pend);

  // R3: a stopped counter holds unless a clear arrives
  assert_halt_R3: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (!t_run && !t_clr_hit) |=> $stable(t_cnt));

  // R5: an arriving clear leaves the count at zero
  assert_clear_R5: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    t_clr_hit |=> (t_cnt == '0));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .clr_pend(clr_pend), .irq(irq),
  .t_run(cfg_t.run), .t_clr_hit(clr_hit_t), .t_cnt(cnt_t)
);

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
  import mt_pkg::*;

  logic        bus_clk = 1'b0;
  logic        tmr_clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        tmr_rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int irq_seen = 0;
  bit done = 1'b0;
  bit prev_irq = 1'b0;
  bit rd_at_edge = 1'b0;

  always #4 bus_clk = ~bus_clk;
  initial begin
    #3;
    forever #20 tmr_clk = ~tmr_clk;
  end

  match_timer u_dut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst), .irq(irq)
  );

  task automatic check_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_range(string tag, longint act, longint lo, longint hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // per-cycle reference: rvalid follows the sampled read strobe, irq is one cycle wide
  always @(posedge bus_clk) rd_at_edge <= bus_rd;
  always @(negedge bus_clk) begin
    if (!bus_rst) begin
      checks++;
      if (bus_rvalid !== rd_at_edge) begin
        failures++;
        $display("FAIL R2 rvalid actual=%0d expected=%0d", bus_rvalid, rd_at_edge);
      end
      checks++;
      if (irq && prev_irq) begin
        failures++;
        $display("FAIL R8 irq width actual=2 expected=1");
      end
      if (irq) irq_seen++;
      prev_irq = irq;
    end
  end

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge bus_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge bus_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge bus_clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_pend(output int cyc);
    logic [31:0] d;
    cyc = 0;
    do begin
      bus_read(OFS_STAT, d);
      cyc += 2;
    end while (d[STAT_PEND] && cyc < 600);
  endtask

  task automatic tmr_wait(int n);
    repeat (n) @(posedge tmr_clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] c1;
    int p1;
    int p2;
    int pc;

    repeat (4) @(posedge tmr_clk);
    @(negedge bus_clk);
    bus_rst = 1'b0;
    tmr_rst = 1'b0;

    // R1 reset values
    bus_read(OFS_MATCH, d);  check_eq("R1 match", d, 0);
    bus_read(OFS_COUNT, d);  check_eq("R1 count", d, 0);
    bus_read(OFS_CTRL, d);   check_eq("R1 ctrl", d, 0);
    bus_read(OFS_CLKSEL, d); check_eq("R1 clksel", d, 0);
    bus_read(OFS_STAT, d);   check_eq("R1 status", d, 0);

    // R2 readback
    bus_write(OFS_MATCH, 32'h0000_1234);
    bus_write(OFS_CTRL, 32'h2);
    bus_write(OFS_CLKSEL, 32'h2);
    bus_read(OFS_MATCH, d);  check_eq("R2 match", d, 32'h1234);
    bus_read(OFS_CTRL, d);   check_eq("R2 ctrl", d, 2);
    bus_read(OFS_CLKSEL, d); check_eq("R2 clksel", d, 2);
    bus_read(8'h18, d);      check_eq("R2 unmapped", d, 0);
    bus_write(OFS_CTRL, 32'h0);
    bus_write(OFS_CLKSEL, 32'h0);
    bus_write(OFS_MATCH, 32'hFFFF_FFFF);

    // R3 counting and halt
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(40);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(4);
    bus_read(OFS_COUNT, c1);
    check_range("R3 count after 40 ticks", c1, 37, 42);
    tmr_wait(20);
    bus_read(OFS_COUNT, d);
    check_eq("R3 halted count", d, c1);

    // R5 / R6 single clear
    bus_write(OFS_CLEAR, 32'hDEAD_BEEF);
    bus_read(OFS_STAT, d);
    check_eq("R6 pending after clear", d[STAT_PEND], 1);
    wait_pend(p1);
    check_range("R6 pending duration", p1, 4, 598);
    bus_read(OFS_COUNT, d);
    check_eq("R5 count zeroed", d, 0);

    // R4 divide by four
    bus_write(OFS_CLKSEL, 32'h3);
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(80);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(6);
    bus_read(OFS_COUNT, d);
    check_range("R4 div4 count", d, 18, 22);
    bus_write(OFS_CLKSEL, 32'h0);

    // R7 merged clear
    bus_write(OFS_CLEAR, 32'h0);
    bus_write(OFS_CLEAR, 32'h0);
    bus_read(OFS_STAT, d);
    check_eq("R7 pending after second clear", d[STAT_PEND], 1);
    wait_pend(p2);
    pc = p2 - p1;
    check_range("R7 extra round trip", pc, 4, 598);
    bus_read(OFS_COUNT, d);
    check_eq("R7 count zeroed", d, 0);

    // R8 single match event, count continues
    bus_write(OFS_MATCH, 32'd10);
    irq_seen = 0;
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(40);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(6);
    check_eq("R8 event count", irq_seen, 1);
    bus_read(OFS_COUNT, d);
    check_range("R8 count past match", d, 30, 44);

    // R9 auto-zero periodic events
    bus_write(OFS_CLEAR, 32'h0);
    wait_pend(pc);
    bus_write(OFS_MATCH, 32'd8);
    irq_seen = 0;
    bus_write(OFS_CTRL, 32'h3);
    tmr_wait(100);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(6);
    check_range("R9 periodic events", irq_seen, 10, 13);
    bus_read(OFS_COUNT, d);
    check_range("R9 count below match", d, 0, 7);

    // R10 stopped timer raises nothing
    bus_write(OFS_CLEAR, 32'h0);
    wait_pend(pc);
    bus_write(OFS_MATCH, 32'd12);
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(6);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(6);
    bus_read(OFS_COUNT, c1);
    check_range("R10 stopped before match", c1, 2, 9);
    irq_seen = 0;
    tmr_wait(40);
    check_eq("R10 no event while stopped", irq_seen, 0);
    bus_read(OFS_COUNT, d);
    check_eq("R10 count unchanged", d, c1);

    // R11 documented sequence from a count far past the compare value
    bus_write(OFS_MATCH, 32'hFFFF_FFFF);
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(50);
    bus_write(OFS_CTRL, 32'h0);
    tmr_wait(6);
    bus_read(OFS_COUNT, d);
    check_range("R11 old count beyond match", d, 40, 70);
    bus_write(OFS_CLEAR, 32'h0);
    bus_write(OFS_MATCH, 32'd6);
    wait_pend(pc);
    check_range("R11 pending settled", pc, 2, 598);
    irq_seen = 0;
    bus_write(OFS_CTRL, 32'h1);
    tmr_wait(20);
    check_eq("R11 event caught", irq_seen, 1);
    bus_write(OFS_CTRL, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule